// File: doc/BRIEF.md
# Sliding-Window Bit-by-Sample Cross-Correlator

This block keeps a matrix of running correlations between a vector of antipodal data bits and a vector of signed received samples. Each accepted update adds the outer product of a new bit vector and a new sample vector into the matrix. When the block is tracking, it also removes the outer product of the entry that is leaving the averaging window. No multipliers are needed, because a bit of value +1 or -1 only decides whether a sample is added or negated.

An update is started with a strobe. The block captures the operands and then walks the matrix in row-major order, one element per cycle, with a read-modify-write on internal storage. It raises a one-cycle done pulse when the last element has been written. The caller supplies the bits and samples of the oldest window entry, so the history buffer sits outside the block. A synchronous clear zeroes the whole matrix, for example before a new pilot sequence begins. A registered read port lets the consuming estimator fetch any element.

Top module: `corr_window_xcorr`

## Requirements
- R1: After reset every matrix element reads zero, and busy_o and done_o are low.
- R2: Bit i of bits_new_i stands for +1 when it is 1 and for -1 when it is 0. Column j's sample is the signed SW-bit field samp_new_i[j*SW +: SW]. An update adds bit_i*sample_j to element (i, j).
- R3: When track_i is high at the start strobe, the update also subtracts bit_old_i*sample_old_j from element (i, j). The old bits and samples use the same encodings as in R2.
- R4: When track_i is low at the start strobe, bits_old_i and samp_old_i have no effect on the matrix.
- R5: An accepted start_i drives busy_o high in the next cycle. busy_o stays high for exactly ROWS*COLS cycles. done_o is high for one cycle, ROWS*COLS edges after the start edge, and in that cycle busy_o returns low.
- R6: Elements are updated in row-major order (index row*COLS+col), one per cycle. Element (0,0) is already updated two edges after the start edge, while the last element still holds its old value.
- R7: A start_i that arrives while busy_o is high is ignored. The matrix then receives only the first update, and no second run follows.
- R8: A cycle with clr_i high zeroes every element, aborts a running update without a done pulse, and takes priority over start_i.
- R9: rd_data_o shows element (rd_row_i, rd_col_i) one clock edge after the address is applied.
- R10: Accumulation wraps modulo 2^AW in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the matrix; aborts a run |
| start_i | input | 1 | Strobe that starts one update; the operands are captured with it |
| track_i | input | 1 | 1 = tracking (remove oldest entry), 0 = training |
| bits_new_i | input | ROWS | New bit vector (1 = +1, 0 = -1) |
| samp_new_i | input | COLS*SW | New sample vector, column j at [j*SW +: SW] |
| bits_old_i | input | ROWS | Bits of the entry leaving the window |
| samp_old_i | input | COLS*SW | Samples of the entry leaving the window |
| rd_row_i | input | $clog2(ROWS) | Read row address |
| rd_col_i | input | $clog2(COLS) | Read column address |
| rd_data_o | output | AW | Registered signed element value |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle pulse after the last element is written |

## Verification
A wrong accumulator or a wrong choice of sign shows up on rd_data_o in the first read after the run's done pulse. The sweep reads back every element after each update, so one bad element cannot stay hidden. A fault in the walk order or in the length of the run shows at busy_o and done_o within ROWS*COLS cycles of the start strobe. A mid-run read of the first and last elements also exposes an order error while the run is still going. A stray path from the old operands would corrupt every training-mode update, and the readback right after that update would catch it.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } corr_state_e;
endpackage

// File: rtl/corr_term.sv
module corr_term #(
  parameter int SW = 8,
  parameter int AW = 16
) (
  input  logic                 b_new_i,
  input  logic [SW-1:0]        s_new_i,
  input  logic                 b_old_i,
  input  logic [SW-1:0]        s_old_i,
  input  logic                 track_i,
  output logic signed [AW-1:0] delta_o
);
  logic signed [AW-1:0] s_new_x, s_old_x, add_term, sub_term;

  assign s_new_x  = {{(AW-SW){s_new_i[SW-1]}}, s_new_i};
  assign s_old_x  = {{(AW-SW){s_old_i[SW-1]}}, s_old_i};
  // bit 1 = +1, bit 0 = -1: multiply is a conditional negate
  assign add_term = b_new_i ? s_new_x : -s_new_x;
  assign sub_term = track_i ? (b_old_i ? s_old_x : -s_old_x) : '0;
  assign delta_o  = add_term - sub_term;
endmodule

// File: rtl/corr_seq.sv
module corr_seq
  import corr_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  output logic          launch_o,
  output logic          we_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          busy_o,
  output logic          done_o
);
  corr_state_e state_q;
  logic        last_col, last_row;

  assign last_col = (col_o == CW'(COLS-1));
  assign last_row = (row_o == RW'(ROWS-1));
  assign busy_o   = (state_q == ST_RUN);
  assign launch_o = start_i && !busy_o && !clr_i;
  assign we_o     = busy_o && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_o   <= '0;
      col_o   <= '0;
      done_o  <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      row_o   <= '0;
      col_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_RUN;
          row_o   <= '0;
          col_o   <= '0;
        end
      end else if (last_col) begin
        col_o <= '0;
        if (last_row) begin
          row_o   <= '0;
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          row_o <= row_o + 1'b1;
        end
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/corr_store.sv
module corr_store #(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  parameter int AW   = 16,
  localparam int DEPTH = ROWS * COLS,
  localparam int DW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [DW-1:0]        waddr_i,
  input  logic signed [AW-1:0] wdelta_i,
  input  logic [DW-1:0]        raddr_i,
  output logic [AW-1:0]        rdata_o
);
  logic [AW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= mem_q[waddr_i] + wdelta_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (int'(raddr_i) < DEPTH) rdata_o <= mem_q[raddr_i];
    else rdata_o <= '0;
  end
endmodule

// File: rtl/corr_window_xcorr.sv
module corr_window_xcorr #(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  parameter int SW   = 8,
  parameter int AW   = 16,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int DW  = $clog2(ROWS * COLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic               track_i,
  input  logic [ROWS-1:0]    bits_new_i,
  input  logic [COLS*SW-1:0] samp_new_i,
  input  logic [ROWS-1:0]    bits_old_i,
  input  logic [COLS*SW-1:0] samp_old_i,
  input  logic [RW-1:0]      rd_row_i,
  input  logic [CW-1:0]      rd_col_i,
  output logic [AW-1:0]      rd_data_o,
  output logic               busy_o,
  output logic               done_o
);
  logic               launch, we;
  logic [RW-1:0]      row;
  logic [CW-1:0]      col;
  logic [ROWS-1:0]    bn_q, bo_q;
  logic [COLS*SW-1:0] sn_q, so_q;
  logic               trk_q;
  logic signed [AW-1:0] delta;
  logic [DW-1:0]      waddr, raddr;

  corr_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk_i, .rst_ni, .clr_i, .start_i,
    .launch_o(launch), .we_o(we), .row_o(row), .col_o(col),
    .busy_o, .done_o
  );

  // operands are held for the whole walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bn_q <= '0; bo_q <= '0; sn_q <= '0; so_q <= '0; trk_q <= 1'b0;
    end else if (launch) begin
      bn_q  <= bits_new_i;
      bo_q  <= bits_old_i;
      sn_q  <= samp_new_i;
      so_q  <= samp_old_i;
      trk_q <= track_i;
    end
  end

  corr_term #(.SW(SW), .AW(AW)) u_term (
    .b_new_i(bn_q[row]),
    .s_new_i(sn_q[int'(col)*SW +: SW]),
    .b_old_i(bo_q[row]),
    .s_old_i(so_q[int'(col)*SW +: SW]),
    .track_i(trk_q),
    .delta_o(delta)
  );

  assign waddr = DW'(row) * DW'(COLS) + DW'(col);
  assign raddr = DW'(rd_row_i) * DW'(COLS) + DW'(rd_col_i);

  corr_store #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_store (
    .clk_i, .rst_ni, .clr_i,
    .we_i(we), .waddr_i(waddr), .wdelta_i(delta),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/corr_window_xcorr_chk.sv
module corr_window_xcorr_chk #(
  parameter int ROWS = 64,
  parameter int COLS = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic start_i,
  input logic busy_o,
  input logic done_o
);
  localparam int TOTAL = ROWS * COLS;
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= 0;
    else if (start_i && !busy_o && !clr_i) run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
  end

  a_r5_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !clr_i) |=> busy_o);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r5_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(clr_i)) |-> done_o);
  a_r5_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == TOTAL));
  a_r7_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i && run_cnt < TOTAL - 1) |=> busy_o);
  a_r8_clear_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!busy_o && !done_o));
endmodule

bind corr_window_xcorr corr_window_xcorr_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/corr_window_xcorr_tb_top.sv
`timescale 1ns/1ps
module corr_window_xcorr_tb_top;
  localparam int ROWS = 4, COLS = 3, SW = 8, AW = 10, TOTAL = ROWS * COLS;

  logic clk_i = 0, rst_ni = 0, clr_i = 0, start_i = 0, track_i = 0;
  logic [ROWS-1:0]    bits_new_i = '0, bits_old_i = '0;
  logic [COLS*SW-1:0] samp_new_i = '0, samp_old_i = '0;
  logic [1:0]         rd_row_i = '0, rd_col_i = '0;
  logic [AW-1:0]      rd_data_o;
  logic               busy_o, done_o;

  int exp_m [ROWS][COLS];
  int sn [COLS];
  int so [COLS];
  int checks = 0, fails = 0;

  corr_window_xcorr #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .AW(AW)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  function automatic int wrap(int v);
    int m = 1 << AW;
    int t = v % m;
    if (t < 0) t += m;
    if (t >= m / 2) t -= m;
    return t;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic load(logic trk, logic [ROWS-1:0] bn, logic [ROWS-1:0] bo);
    track_i = trk; bits_new_i = bn; bits_old_i = bo;
    for (int j = 0; j < COLS; j++) begin
      samp_new_i[j*SW +: SW] = SW'(sn[j]);
      samp_old_i[j*SW +: SW] = SW'(so[j]);
    end
  endtask

  task automatic model();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int d = bits_new_i[r] ? sn[c] : -sn[c];
        if (track_i) d -= bits_old_i[r] ? so[c] : -so[c];
        exp_m[r][c] = wrap(exp_m[r][c] + d);
      end
  endtask

  task automatic rd(int r, int c, output int v);
    logic signed [AW-1:0] sv;
    rd_row_i = 2'(r); rd_col_i = 2'(c);
    @(posedge clk_i); #1;
    sv = rd_data_o;
    v = int'(sv);
  endtask

  task automatic check_all(string req);
    int v;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rd(r, c, v);
        chk(req, v, exp_m[r][c]);
      end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 100) begin @(posedge clk_i); #1; n++; end
  endtask

  task automatic run(string req);
    int n;
    start_i = 1;
    @(posedge clk_i); #1;
    start_i = 0;
    model();
    chk({req, " busy after start R5"}, int'(busy_o), 1);
    wait_done(n);
    chk({req, " done latency R5"}, n, TOTAL);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, n, old_last, dn;
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) exp_m[r][c] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(posedge clk_i); #1;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    check_all("R1 R9 reset zero");

    // R2/R4: training sweep with junk on the old-entry inputs
    for (int t = 0; t < 6; t++) begin
      for (int j = 0; j < COLS; j++) begin
        sn[j] = (t == 0) ? 127 : (t == 1) ? -128 : ((t * 37 + j * 53) % 256) - 128;
        so[j] = ((t * 91 + j * 17) % 256) - 128;
      end
      load(1'b0, ROWS'(t * 5 + 3), ROWS'(~(t * 7)));
      run("R2 R4 training");
      check_all("R2 R4 training readback");
    end

    // R6: row-major walk observed mid-run
    for (int j = 0; j < COLS; j++) begin sn[j] = 50 + j; so[j] = 0; end
    load(1'b0, 4'b1010, 4'b0000);
    old_last = exp_m[ROWS-1][COLS-1];
    start_i = 1;
    @(posedge clk_i); #1;
    start_i = 0;
    model();
    rd(0, 0, v);
    rd(0, 0, v);
    chk("R6 first element early", v, exp_m[0][0]);
    rd(ROWS - 1, COLS - 1, v);
    chk("R6 last element still old", v, old_last);
    wait_done(n);
    check_all("R6 after run");

    // R7: second start during a run is ignored
    for (int j = 0; j < COLS; j++) begin sn[j] = -20 - 3 * j; so[j] = 9; end
    load(1'b0, 4'b0110, 4'b1111);
    start_i = 1;
    @(posedge clk_i); #1;
    start_i = 0;
    model();
    repeat (3) @(posedge clk_i); #1;
    bits_new_i = 4'b1001; samp_new_i = '1;
    start_i = 1;
    @(posedge clk_i); #1;
    start_i = 0;
    wait_done(n);
    @(posedge clk_i); #1;
    chk("R7 no second run", int'(busy_o), 0);
    check_all("R7 single update");

    // R3: tracking removes the oldest entry
    for (int t = 0; t < 5; t++) begin
      for (int j = 0; j < COLS; j++) begin
        sn[j] = ((t * 29 + j * 71) % 256) - 128;
        so[j] = (t == 0) ? -128 : ((t * 43 + j * 11) % 256) - 128;
      end
      load(1'b1, ROWS'(t * 3 + 1), ROWS'(t * 6 + 5));
      run("R3 tracking");
      check_all("R3 tracking readback");
    end

    // R10: repeated maximum adds wrap modulo 2^AW
    for (int t = 0; t < 6; t++) begin
      for (int j = 0; j < COLS; j++) begin sn[j] = 127; so[j] = 0; end
      load(1'b0, 4'b1111, 4'b0000);
      run("R10 wrap");
    end
    check_all("R10 wrap readback");

    // R8: clear aborts a run
    for (int j = 0; j < COLS; j++) begin sn[j] = 33; so[j] = 0; end
    load(1'b0, 4'b1100, 4'b0000);
    start_i = 1;
    @(posedge clk_i); #1;
    start_i = 0;
    repeat (4) @(posedge clk_i); #1;
    clr_i = 1;
    @(posedge clk_i); #1;
    clr_i = 0;
    chk("R8 busy after clear", int'(busy_o), 0);
    dn = 0;
    for (int k = 0; k < 20; k++) begin @(posedge clk_i); #1; dn += int'(done_o); end
    chk("R8 no done after clear", dn, 0);
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) exp_m[r][c] = 0;
    check_all("R8 cleared matrix");
    clr_i = 1; start_i = 1;
    @(posedge clk_i); #1;
    clr_i = 0; start_i = 0;
    chk("R8 clear beats start", int'(busy_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule